// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block sits between a processor load/store port and a single-word memory port. It keeps a direct-mapped array of one-word lines. Each line carries a valid flag, a dirty flag, a tag and a data word. Loads and stores that hit are served from the array without any memory traffic. A store hit only marks the line modified, so memory keeps the old value until that line is displaced.

On a miss, a small state machine handles the line. If the line it displaces is modified, the machine first writes that line out to memory. It then reads the wanted word in. After that it retries the lookup, which now hits. A store miss therefore allocates the line first and merges the store data afterwards. One processor access thus costs zero, one or two memory transactions.

The processor offers a request when `cpu_ready_o` is high. `cpu_ready_o` stays low from acceptance until the single-cycle `cpu_done_o` pulse.

Top module: `cwb_cache`

## Requirements
- R1: After reset every line is invalid and clean. `cpu_ready_o` is 1, and `cpu_done_o` and `mem_req_o` are 0. The first access to any index misses and never causes a memory write.
- R2: A load hit raises `cpu_done_o` in the cycle after acceptance, with the cached word on `cpu_rdata_o`, and issues no memory transaction.
- R3: A store hit updates only the cached word and marks the line dirty. It issues no memory transaction, and memory keeps its previous value for that word.
- R4: A load miss whose line is invalid or clean issues exactly one memory read. The read address is the request's word address. The line is filled clean and the load returns the memory word.
- R5: A store miss first reads the word from memory, then overwrites it with the store data and leaves the line dirty. Memory is not written by that access.
- R6: A miss on a valid dirty line writes the old word to memory first. The write address is rebuilt from the stored tag and the current index, and a write is always followed directly by the refill read.
- R7: `cpu_ready_o` is low from the cycle after acceptance until the cycle after `cpu_done_o`. Exactly one `cpu_done_o` pulse occurs per accepted request, and `cpu_done_o` is never high while `mem_req_o` is high.
- R8: With default parameters, address bits [1:0] are a byte offset that is ignored, bits [11:2] are the index and bits [31:12] are the tag. Every memory address has bits [1:0] equal to 0.
- R9: Once `mem_req_o` is raised, it and `mem_we_o`, `mem_addr_o` and `mem_wdata_o` hold steady until the cycle in which `mem_ack_i` is seen.
- R10: The number of memory transactions per access is 0 on a hit, 1 on a miss with a clean or invalid line, and 2 on a miss with a dirty line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, taken when cpu_ready_o is high |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Byte address |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_ready_o | output | 1 | Controller idle and able to take a request |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Load data, valid with cpu_done_o on loads |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_wdata_o | output | DATA_W | Victim data for write-back |
| mem_ack_i | input | 1 | Memory completes the current transaction |
| mem_rdata_i | input | DATA_W | Memory read data, valid with mem_ack_i |

## Verification
Within one access, the eviction of a modified line and the allocation of a new tag at the same index both happen. The hardest case is a store miss onto a dirty line, where write-back, refill and the store merge all land on one index. The bench provokes this with directed conflict pairs, followed by random traffic confined to a few tags and indices so that conflicts are frequent. A reference model of valid, dirty and tag state per line, plus a shadow of the true memory contents, predicts the transaction count, the write-back address and data, the refill address and every load value. Each outcome is compared against those predictions.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_WRITEBACK,
    ST_REFILL
  } cwb_state_e;
endpackage

// File: rtl/cwb_addr_split.sv
module cwb_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic unused_off;
  assign unused_off = ^addr_i[OFF_W-1:0];
  assign tag_o = addr_i[ADDR_W-1 -: TAG_W];
  assign idx_o = addr_i[OFF_W +: IDX_W];
endmodule

// File: rtl/cwb_tag_store.sv
module cwb_tag_store #(
  parameter int LINES = 1024,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             fill_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             dirty_set_i,
  output logic             valid_o,
  output logic             dirty_o,
  output logic [TAG_W-1:0] tag_o
);
  logic [LINES-1:0] valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (dirty_set_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[idx_i] <= fill_tag_i;
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign tag_o   = tag_q[idx_i];
endmodule

// File: rtl/cwb_data_store.sv
module cwb_data_store #(
  parameter int LINES  = 1024,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [LINES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
  import cwb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic req_we_i,
  input  logic hit_i,
  input  logic victim_dirty_i,
  input  logic mem_ack_i,
  output logic ready_o,
  output logic done_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic fill_o,
  output logic store_o
);
  cwb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (req_i) state_d = ST_COMPARE;
      ST_COMPARE:   state_d = hit_i ? ST_IDLE : (victim_dirty_i ? ST_WRITEBACK : ST_REFILL);
      ST_WRITEBACK: if (mem_ack_i) state_d = ST_REFILL;
      ST_REFILL:    if (mem_ack_i) state_d = ST_COMPARE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign done_o    = (state_q == ST_COMPARE) && hit_i;
  assign mem_req_o = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL);
  assign mem_we_o  = (state_q == ST_WRITEBACK);
  assign fill_o    = (state_q == ST_REFILL) && mem_ack_i;
  // store merges after a refill too: retried compare hits
  assign store_o   = done_o && req_we_i;
endmodule

// File: rtl/cwb_cache.sv
module cwb_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 1024,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(DATA_W / 8),
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [TAG_W-1:0]  in_tag, q_tag, line_tag;
  logic [IDX_W-1:0]  in_idx, q_idx;
  logic              q_we;
  logic [DATA_W-1:0] q_wdata, line_data, data_wdata;
  logic              line_valid, line_dirty, hit;
  logic              fill, store, accept;

  cwb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
    .addr_i(cpu_addr_i), .tag_o(in_tag), .idx_o(in_idx)
  );

  assign accept = cpu_req_i && cpu_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_tag   <= '0;
      q_idx   <= '0;
      q_we    <= 1'b0;
      q_wdata <= '0;
    end else if (accept) begin
      q_tag   <= in_tag;
      q_idx   <= in_idx;
      q_we    <= cpu_we_i;
      q_wdata <= cpu_wdata_i;
    end
  end

  cwb_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(q_idx),
    .fill_i(fill), .fill_tag_i(q_tag), .dirty_set_i(store),
    .valid_o(line_valid), .dirty_o(line_dirty), .tag_o(line_tag)
  );

  assign data_wdata = fill ? mem_rdata_i : q_wdata;

  cwb_data_store #(.LINES(LINES), .DATA_W(DATA_W)) u_data (
    .clk_i(clk_i), .idx_i(q_idx), .we_i(fill | store),
    .wdata_i(data_wdata), .rdata_o(line_data)
  );

  assign hit = line_valid && (line_tag == q_tag);

  cwb_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(cpu_req_i), .req_we_i(q_we),
    .hit_i(hit), .victim_dirty_i(line_valid && line_dirty),
    .mem_ack_i(mem_ack_i), .ready_o(cpu_ready_o), .done_o(cpu_done_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .fill_o(fill), .store_o(store)
  );

  // victim address rebuilt from stored tag, current index
  assign mem_addr_o  = {(mem_we_o ? line_tag : q_tag), q_idx, {OFF_W{1'b0}}};
  assign mem_wdata_o = line_data;
  assign cpu_rdata_o = line_data;
endmodule

// File: rtl/cwb_cache_chk.sv
module cwb_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 1024,
  localparam int IDX_W = $clog2(LINES),
  localparam int OFF_W = $clog2(DATA_W / 8)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_ready_o,
  input logic              cpu_done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i
);
  logic [LINES-1:0] filled_q;
  logic [IDX_W-1:0] m_idx;
  assign m_idx = mem_addr_o[OFF_W +: IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) filled_q <= '0;
    else if (mem_req_o && !mem_we_o && mem_ack_i) filled_q[m_idx] <= 1'b1;
  end

  assert_wb_after_fill_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> filled_q[m_idx]);

  assert_done_blocks_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> !cpu_ready_o);

  assert_ready_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> cpu_ready_o);

  assert_done_no_mem_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> !mem_req_o);

  assert_mem_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[OFF_W-1:0] == '0));

  assert_mem_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_wb_then_refill_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ack_i |=> mem_req_o && !mem_we_o);
endmodule

bind cwb_cache cwb_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_ready_o(cpu_ready_o), .cpu_done_o(cpu_done_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i)
);

// File: tb/cwb_cache_bench.sv
module cwb_cache_bench;
  localparam int AW = 32, DW = 32, LN = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready, cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #10 clk = ~clk;

  cwb_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(LN)) u_cwb_cache (
    .clk_i(clk), .rst_ni(rst_n), .cpu_req_i(cpu_req), .cpu_we_i(cpu_we),
    .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_ready_o(cpu_ready),
    .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic [DW-1:0] mem_model [logic [AW-1:0]];
  logic [DW-1:0] shadow    [logic [AW-1:0]];
  bit            ref_valid [LN];
  bit            ref_dirty [LN];
  logic [19:0]   ref_tag   [LN];

  int rd_cnt, wb_cnt;
  logic [AW-1:0] rd_addr_log, wb_addr_log;
  logic [DW-1:0] wb_data_log;

  function automatic logic [DW-1:0] init_word(logic [AW-1:0] a);
    return (a * 32'h9E37_79B9) ^ 32'h1234_5678;
  endfunction

  function automatic logic [DW-1:0] mem_rd(logic [AW-1:0] a);
    return mem_model.exists(a) ? mem_model[a] : init_word(a);
  endfunction

  function automatic logic [DW-1:0] truth(logic [AW-1:0] a);
    return shadow.exists(a) ? shadow[a] : init_word(a);
  endfunction

  // memory model: one wait cycle, then ack
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin
        mem_model[mem_addr] = mem_wdata;
        wb_cnt++;
        wb_addr_log = mem_addr;
        wb_data_log = mem_wdata;
      end else begin
        rd_cnt++;
        rd_addr_log = mem_addr;
      end
    end
    mem_rdata <= mem_req ? mem_rd(mem_addr) : '0;
    mem_ack   <= mem_req && !mem_ack;
  end

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic access(bit we, logic [AW-1:0] addr, logic [DW-1:0] wd);
    logic [AW-1:0] wa = {addr[AW-1:2], 2'b00};
    logic [9:0]  idx = addr[11:2];
    logic [19:0] tg  = addr[31:12];
    bit hit = ref_valid[idx] && ref_tag[idx] == tg;
    bit exp_wb = !hit && ref_valid[idx] && ref_dirty[idx];
    logic [AW-1:0] vict = {ref_tag[idx], idx, 2'b00};
    logic [DW-1:0] mem_before = mem_rd(wa);
    int cyc = 0;
    @(negedge clk);
    check(cpu_ready == 1'b1, "R7", "ready before request", 64'(cpu_ready), 1);
    rd_cnt = 0; wb_cnt = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_done && cyc < 40) begin
      if (cpu_ready) begin
        check(0, "R7", "ready high before done", 64'(cpu_ready), 0);
        break;
      end
      @(negedge clk);
      cyc++;
    end
    if (!cpu_done) begin
      check(0, "R7", "done timeout", 64'(cyc), 0);
      return;
    end
    if (hit) check(cyc == 0, "R2", "hit latency", 64'(cyc), 0);
    check(rd_cnt == (hit ? 0 : 1), "R10", "read count", 64'(rd_cnt), 64'(hit ? 0 : 1));
    check(wb_cnt == (exp_wb ? 1 : 0), "R10", "writeback count", 64'(wb_cnt), 64'(exp_wb));
    if (!hit) check(rd_addr_log == wa, "R4", "refill address", 64'(rd_addr_log), 64'(wa));
    if (exp_wb) begin
      check(wb_addr_log == vict, "R6", "writeback address", 64'(wb_addr_log), 64'(vict));
      check(wb_data_log == truth(vict), "R6", "writeback data", 64'(wb_data_log), 64'(truth(vict)));
    end
    if (!we) check(cpu_rdata == truth(wa), "R2", "load data", 64'(cpu_rdata), 64'(truth(wa)));
    else check(mem_rd(wa) == mem_before, "R3", "memory stale after store", 64'(mem_rd(wa)), 64'(mem_before));
    @(negedge clk);
    check(cpu_ready == 1'b1 && cpu_done == 1'b0, "R7", "ready after done", 64'(cpu_ready), 1);
    if (!hit) begin
      ref_valid[idx] = 1; ref_tag[idx] = tg; ref_dirty[idx] = 0;
    end
    if (we) begin
      ref_dirty[idx] = 1;
      shadow[wa] = wd;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(0, "R7", "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20251));
    for (int i = 0; i < LN; i++) begin
      ref_valid[i] = 0; ref_dirty[i] = 0; ref_tag[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(cpu_ready == 1 && cpu_done == 0 && mem_req == 0, "R1", "reset outputs",
          {cpu_ready, cpu_done, mem_req}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ready == 1 && mem_req == 0, "R1", "idle after reset", 64'(mem_req), 0);

    access(0, 32'h0000_0010, '0);            // R4 / R1: cold miss, read only
    access(0, 32'h0000_0010, '0);            // R2 hit
    access(0, 32'h0000_0013, '0);            // R8 byte offset ignored
    access(1, 32'h0000_0012, 32'hCAFE_0001); // R3 store hit
    access(0, 32'h0000_0010, '0);            // R3 cache holds new data
    access(0, 32'h0000_1010, '0);            // R6 dirty victim evicted
    check(mem_rd(32'h10) == 32'hCAFE_0001, "R6", "evicted data in memory",
          64'(mem_rd(32'h10)), 64'h CAFE_0001);
    access(1, 32'h0000_2010, 32'hBEEF_0002); // R5 store miss, clean victim
    access(0, 32'h0000_2010, '0);            // R5 merged data, hit
    access(1, 32'hFFFF_F010, 32'h0BAD_0003); // R5+R6 store miss on dirty line
    access(0, 32'h0000_2010, '0);            // R6 refill of evicted store
    access(0, 32'h0000_0FFC, '0);            // R8 last index

    for (int i = 0; i < 600; i++) begin
      logic [19:0] tg;
      logic [9:0]  ix;
      logic [AW-1:0] a;
      case ($urandom_range(0, 3))
        0: tg = 20'h0;
        1: tg = 20'h1;
        2: tg = 20'h7;
        default: tg = 20'hFFFFF;
      endcase
      ix = ($urandom_range(0, 7) == 7) ? 10'h3FF : 10'($urandom_range(0, 5));
      a = {tg, ix, 2'($urandom_range(0, 3))};
      access(1'($urandom_range(0, 1)), a, $urandom());
    end
    summary();
  end
endmodule